// File: doc/BRIEF.md
# DRAM Strobe Timing Checker

This block is a passive monitor for an asynchronous-strobe DRAM interface. It watches the row strobe, the two byte-lane column strobes and the write-enable line on a fast sampling clock. It times the intervals between their edges and raises a sticky flag whenever an interval breaks a minimum or maximum limit. Every limit is a parameter counted in sampling-clock cycles, so a 500 MHz clock gives 2 ns resolution. All strobes are active low. The column strobe used for timing and for classifying cycles is the logical OR of the two byte lanes being low.

The monitor also sorts every row-strobe low period into one of four kinds: read, write, row-only refresh, or column-before-row refresh. The sort depends on the order in which the strobes fall. Each kind has its own counter, and that counter advances once, when the row strobe returns high. One code register keeps the identity of the first violation seen after reset, so a later failure cannot hide the first one.

Top module: `dstc_strobe_monitor`

## Requirements
- R1: A column strobe that is low at the first sample where the row strobe is seen low, including the case where both fall on the same sample, marks the cycle as a column-before-row refresh. This holds when the column strobe was left low from a previous access (hidden refresh).
- R2: A row-strobe low period in which no column strobe falls is counted as a row-only refresh.
- R3: A column strobe that falls while the row strobe is low, after a row fall that saw the column strobe high, marks the cycle as an access. The first such fall decides the kind: write if write-enable is low on that sample, read otherwise. Either byte lane counts as the column strobe.
- R4: When the row strobe rises, exactly one cycle counter advances, by one. No counter changes on any other cycle.
- R5: Code 1: the row strobe was high for fewer than T_RP_MIN samples before it fell.
- R6: Code 2: the row strobe was low for fewer than T_RAS_MIN samples. Code 3: the row strobe stays low for more than T_RAS_MAX samples.
- R7: Code 4: fewer than T_RC_MIN samples separate two successive row-strobe falls.
- R8: Code 5: a column-strobe low pulse is shorter than T_CAS_MIN samples. Code 6: the row strobe falls fewer than T_CRP_MIN samples after the column strobe rose. Code 6 is checked only when the column strobe is high at that row fall.
- R9: Code 7: in an access cycle, the row strobe rises fewer than T_RSH_MIN samples after the most recent column-strobe fall. This check does not apply to refresh cycles.
- R10: Code 8: in an access cycle, fewer than T_CSH_MIN samples separate the row fall from the last column-strobe rise. If the column strobe is still low when the row strobe rises, the row rise is used in place of the last column rise.
- R11: Code 9: a write-enable low pulse is shorter than T_WP_MIN samples.
- R12: Each violation code k sets flag bit k-1, and that bit stays set until reset. The code output holds the first nonzero code after reset. When several codes fire on the same sample, the lowest code wins. Reset clears all flags, the code and the counters to zero.
- R13: A line that reads low on N consecutive samples has a width of N. Intervals between edges count samples in the same way. Minimum limits fail only when the count is strictly below the limit, and maximum limits fail only when it is strictly above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| viol_flags | output | 9 | Sticky violation flags, bit k-1 for code k |
| viol_code | output | 4 | First violation code after reset, 0 if none |
| cnt_read | output | CNT_W | Read cycles seen |
| cnt_write | output | CNT_W | Write cycles seen |
| cnt_ror | output | CNT_W | Row-only refresh cycles seen |
| cnt_cbr | output | CNT_W | Column-before-row refresh cycles seen |

## Verification
The bench builds the monitor with very small limits (row high 3, row low 4 to 20, period 9, column pulse 2, precharge gap 2, row hold 2, column hold 5, write pulse 2) and 8-bit counters. With limits this small, every interval can be swept one sample at a time across its boundary, including the over-length row pulse. Each sweep starts from reset, and the expected flag, code and counters are computed in the bench from the swept length. Extra scenarios cover page-mode column pulses, hidden refresh, strobes falling together, ordering of the first code, and codes that fire on the same sample.

// File: rtl/dstc_pkg.sv
package dstc_pkg;

    localparam int NUM_VIOL  = 9;
    localparam int CODE_W    = 4;

    // sampled line indices
    localparam int LN_RAS    = 0;
    localparam int LN_CAS    = 1;
    localparam int LN_WE     = 2;
    localparam int NUM_LINES = 3;

    // interval timer indices
    localparam int TM_RAS_FALL = 0;
    localparam int TM_RAS_RISE = 1;
    localparam int TM_CAS_FALL = 2;
    localparam int TM_CAS_RISE = 3;
    localparam int TM_WE_FALL  = 4;
    localparam int NUM_TIMERS  = 5;

    typedef enum logic [CODE_W-1:0] {
        VC_NONE          = 4'd0,
        VC_ROW_HIGH_SHORT = 4'd1,
        VC_ROW_LOW_SHORT  = 4'd2,
        VC_ROW_LOW_LONG   = 4'd3,
        VC_PERIOD_SHORT   = 4'd4,
        VC_COL_PULSE      = 4'd5,
        VC_COL_TO_ROW_GAP = 4'd6,
        VC_ROW_HOLD       = 4'd7,
        VC_COL_HOLD       = 4'd8,
        VC_WRITE_PULSE    = 4'd9
    } viol_code_e;

    typedef enum logic [1:0] {
        CYC_ROW_ONLY = 2'd0,
        CYC_CBR      = 2'd1,
        CYC_READ     = 2'd2,
        CYC_WRITE    = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        logic      active;
        cyc_kind_e kind;
    } cyc_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // lowest set hit gives its code (bit i -> code i+1); zero if none
    function automatic logic [CODE_W-1:0] lowest_code(input logic [NUM_VIOL-1:0] hits);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int i = NUM_VIOL - 1; i >= 0; i--) begin
            if (hits[i]) c = CODE_W'(i + 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/dstc_edge.sv
module dstc_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise,
    output logic [N-1:0] low
);
    logic [N-1:0] s0;
    logic [N-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s0 <= '1;
            s1 <= '1;
        end else begin
            s0 <= line_n;
            s1 <= s0;
        end
    end

    assign low  = ~s0;
    assign fall = s1 & ~s0;
    assign rise = ~s1 & s0;
endmodule

// File: rtl/dstc_interval.sv
module dstc_interval #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic [W-1:0] elapsed
);
    // saturates at all-ones, which also means "no start seen yet"
    always_ff @(posedge clk) begin
        if (rst)                 elapsed <= '1;
        else if (start)          elapsed <= W'(1);
        else if (elapsed != '1)  elapsed <= elapsed + W'(1);
    end
endmodule

// File: rtl/dstc_cycle_class.sv
module dstc_cycle_class
    import dstc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_fall,
    input  logic             ras_rise,
    input  logic             cas_fall,
    input  logic             cas_low,
    input  logic             we_low,
    output logic             is_access,
    output logic [CNT_W-1:0] n_read,
    output logic [CNT_W-1:0] n_write,
    output logic [CNT_W-1:0] n_ror,
    output logic [CNT_W-1:0] n_cbr
);
    cyc_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.active <= 1'b0;
            st.kind   <= CYC_ROW_ONLY;
            n_read    <= '0;
            n_write   <= '0;
            n_ror     <= '0;
            n_cbr     <= '0;
        end else if (ras_fall) begin
            st.active <= 1'b1;
            st.kind   <= cas_low ? CYC_CBR : CYC_ROW_ONLY;
        end else if (ras_rise) begin
            st.active <= 1'b0;
            if (st.active) begin
                case (st.kind)
                    CYC_READ:  n_read  <= n_read  + CNT_W'(1);
                    CYC_WRITE: n_write <= n_write + CNT_W'(1);
                    CYC_CBR:   n_cbr   <= n_cbr   + CNT_W'(1);
                    default:   n_ror   <= n_ror   + CNT_W'(1);
                endcase
            end
        end else if (st.active && st.kind == CYC_ROW_ONLY && cas_fall) begin
            st.kind <= we_low ? CYC_WRITE : CYC_READ;
        end
    end

    assign is_access = st.active && (st.kind == CYC_READ || st.kind == CYC_WRITE);
endmodule

// File: rtl/dstc_viol_latch.sv
module dstc_viol_latch
    import dstc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_VIOL-1:0] hits,
    output logic [NUM_VIOL-1:0] flags,
    output logic [CODE_W-1:0]   code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            code  <= '0;
        end else begin
            flags <= flags | hits;
            if (code == '0) code <= lowest_code(hits);
        end
    end
endmodule

// File: rtl/dstc_strobe_monitor.sv
module dstc_strobe_monitor
    import dstc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int T_RP_MIN  = 15,
    parameter int T_RAS_MIN = 25,
    parameter int T_RAS_MAX = 5000,
    parameter int T_RC_MIN  = 42,
    parameter int T_CAS_MIN = 4,
    parameter int T_CRP_MIN = 3,
    parameter int T_RSH_MIN = 7,
    parameter int T_CSH_MIN = 20,
    parameter int T_WP_MIN  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ras_n,
    input  logic                ucas_n,
    input  logic                lcas_n,
    input  logic                we_n,
    output logic [NUM_VIOL-1:0] viol_flags,
    output logic [CODE_W-1:0]   viol_code,
    output logic [CNT_W-1:0]    cnt_read,
    output logic [CNT_W-1:0]    cnt_write,
    output logic [CNT_W-1:0]    cnt_ror,
    output logic [CNT_W-1:0]    cnt_cbr
);
    localparam int unsigned TOP_LIM = max2(max2(max2(T_RAS_MAX, T_RC_MIN), max2(T_CSH_MIN, T_RP_MIN)),
                                           max2(max2(T_RAS_MIN, T_CAS_MIN), max2(max2(T_CRP_MIN, T_RSH_MIN), T_WP_MIN)));
    localparam int TW = $clog2(TOP_LIM + 2);

    localparam logic [TW-1:0] LIM_RP     = TW'(T_RP_MIN);
    localparam logic [TW-1:0] LIM_RASMIN = TW'(T_RAS_MIN);
    localparam logic [TW-1:0] LIM_RASMAX = TW'(T_RAS_MAX);
    localparam logic [TW-1:0] LIM_RC     = TW'(T_RC_MIN);
    localparam logic [TW-1:0] LIM_CAS    = TW'(T_CAS_MIN);
    localparam logic [TW-1:0] LIM_CRP    = TW'(T_CRP_MIN);
    localparam logic [TW-1:0] LIM_RSH    = TW'(T_RSH_MIN);
    localparam logic [TW-1:0] LIM_CSH    = TW'(T_CSH_MIN);
    localparam logic [TW-1:0] LIM_WP     = TW'(T_WP_MIN);

    // ---- sampling and edge detection ----
    logic [NUM_LINES-1:0] line_n, l_fall, l_rise, l_low;

    assign line_n[LN_RAS] = ras_n;
    assign line_n[LN_CAS] = ucas_n & lcas_n;   // either lane low = column strobe low
    assign line_n[LN_WE]  = we_n;

    dstc_edge #(.N(NUM_LINES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_n (line_n),
        .fall   (l_fall),
        .rise   (l_rise),
        .low    (l_low)
    );

    logic ras_fall, ras_rise, ras_low;
    logic cas_fall, cas_rise, cas_low;
    logic we_fall, we_rise, we_low;

    assign ras_fall = l_fall[LN_RAS];
    assign ras_rise = l_rise[LN_RAS];
    assign ras_low  = l_low[LN_RAS];
    assign cas_fall = l_fall[LN_CAS];
    assign cas_rise = l_rise[LN_CAS];
    assign cas_low  = l_low[LN_CAS];
    assign we_fall  = l_fall[LN_WE];
    assign we_rise  = l_rise[LN_WE];
    assign we_low   = l_low[LN_WE];

    // ---- interval timers, one per reference edge ----
    logic [NUM_TIMERS-1:0] tm_start;
    logic [TW-1:0]         elapsed [NUM_TIMERS];

    assign tm_start[TM_RAS_FALL] = ras_fall;
    assign tm_start[TM_RAS_RISE] = ras_rise;
    assign tm_start[TM_CAS_FALL] = cas_fall;
    assign tm_start[TM_CAS_RISE] = cas_rise;
    assign tm_start[TM_WE_FALL]  = we_fall;

    generate
        for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tm
            dstc_interval #(.W(TW)) u_tm (
                .clk     (clk),
                .rst     (rst),
                .start   (tm_start[g]),
                .elapsed (elapsed[g])
            );
        end
    endgenerate

    // time from row fall to the latest column rise inside the row cycle
    logic [TW-1:0] cas_hold_q;
    logic [TW-1:0] cas_hold_now;

    always_ff @(posedge clk) begin
        if (rst)                      cas_hold_q <= '1;
        else if (cas_rise && ras_low) cas_hold_q <= elapsed[TM_RAS_FALL];
    end

    assign cas_hold_now = (cas_low || cas_rise) ? elapsed[TM_RAS_FALL] : cas_hold_q;

    // ---- cycle classification ----
    logic is_access;

    dstc_cycle_class #(.CNT_W(CNT_W)) u_class (
        .clk       (clk),
        .rst       (rst),
        .ras_fall  (ras_fall),
        .ras_rise  (ras_rise),
        .cas_fall  (cas_fall),
        .cas_low   (cas_low),
        .we_low    (we_low),
        .is_access (is_access),
        .n_read    (cnt_read),
        .n_write   (cnt_write),
        .n_ror     (cnt_ror),
        .n_cbr     (cnt_cbr)
    );

    // ---- limit checks ----
    logic [NUM_VIOL-1:0] hits;

    always_comb begin
        hits = '0;
        hits[int'(VC_ROW_HIGH_SHORT)-1] = ras_fall && (elapsed[TM_RAS_RISE] < LIM_RP);
        hits[int'(VC_ROW_LOW_SHORT)-1]  = ras_rise && (elapsed[TM_RAS_FALL] < LIM_RASMIN);
        hits[int'(VC_ROW_LOW_LONG)-1]   = ras_low && !ras_fall && (elapsed[TM_RAS_FALL] >= LIM_RASMAX);
        hits[int'(VC_PERIOD_SHORT)-1]   = ras_fall && (elapsed[TM_RAS_FALL] < LIM_RC);
        hits[int'(VC_COL_PULSE)-1]      = cas_rise && (elapsed[TM_CAS_FALL] < LIM_CAS);
        hits[int'(VC_COL_TO_ROW_GAP)-1] = ras_fall && !cas_low && (elapsed[TM_CAS_RISE] < LIM_CRP);
        hits[int'(VC_ROW_HOLD)-1]       = ras_rise && is_access && (elapsed[TM_CAS_FALL] < LIM_RSH);
        hits[int'(VC_COL_HOLD)-1]       = ras_rise && is_access && (cas_hold_now < LIM_CSH);
        hits[int'(VC_WRITE_PULSE)-1]    = we_rise && (elapsed[TM_WE_FALL] < LIM_WP);
    end

    dstc_viol_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .hits  (hits),
        .flags (viol_flags),
        .code  (viol_code)
    );
endmodule

// File: rtl/dstc_strobe_monitor_chk.sv
module dstc_strobe_monitor_chk
    import dstc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                ras_rise,
    input logic [NUM_VIOL-1:0] viol_flags,
    input logic [CODE_W-1:0]   viol_code,
    input logic [CNT_W-1:0]    cnt_read,
    input logic [CNT_W-1:0]    cnt_write,
    input logic [CNT_W-1:0]    cnt_ror,
    input logic [CNT_W-1:0]    cnt_cbr
);
    assert_flags_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

    assert_code_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        (viol_code != '0) |=> $stable(viol_code));

    assert_code_iff_flag_R12: assert property (@(posedge clk) disable iff (rst)
        ((viol_code == '0) == (viol_flags == '0)));

    assert_code_has_flag_R12: assert property (@(posedge clk) disable iff (rst)
        (viol_code != '0) |-> viol_flags[viol_code - 4'd1]);

    assert_count_only_at_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !ras_rise |=> ($stable(cnt_read) && $stable(cnt_write) && $stable(cnt_ror) && $stable(cnt_cbr)));

    assert_one_count_per_rise_R4: assert property (@(posedge clk) disable iff (rst)
        ras_rise |=> ($countones({cnt_read != $past(cnt_read), cnt_write != $past(cnt_write),
                                  cnt_ror != $past(cnt_ror), cnt_cbr != $past(cnt_cbr)}) == 1));
endmodule

bind dstc_strobe_monitor dstc_strobe_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ras_rise   (ras_rise),
    .viol_flags (viol_flags),
    .viol_code  (viol_code),
    .cnt_read   (cnt_read),
    .cnt_write  (cnt_write),
    .cnt_ror    (cnt_ror),
    .cnt_cbr    (cnt_cbr)
);

// File: tb/dstc_strobe_monitor_bench.sv
module dstc_strobe_monitor_bench;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1;
    logic [8:0]    viol_flags;
    logic [3:0]    viol_code;
    logic [CW-1:0] cnt_read, cnt_write, cnt_ror, cnt_cbr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dstc_strobe_monitor #(
        .CNT_W(CW), .T_RP_MIN(3), .T_RAS_MIN(4), .T_RAS_MAX(20), .T_RC_MIN(9),
        .T_CAS_MIN(2), .T_CRP_MIN(2), .T_RSH_MIN(2), .T_CSH_MIN(5), .T_WP_MIN(2)
    ) u_dstc_strobe_monitor (
        .clk(clk), .rst(rst), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n),
        .viol_flags(viol_flags), .viol_code(viol_code),
        .cnt_read(cnt_read), .cnt_write(cnt_write), .cnt_ror(cnt_ror), .cnt_cbr(cnt_cbr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // every call starts on a falling clock edge; values are held for n samples
    task automatic hold(input logic r, input logic u, input logic l, input logic w, input int n);
        ras_n = r; ucas_n = u; lcas_n = l; we_n = w;
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_trial();
        rst = 1'b1;
        ras_n = 1'b1; ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic int mask_of(input int code);
        return (code == 0) ? 0 : (1 << (code - 1));
    endfunction

    task automatic end_trial(input string req, input int flags, input int code,
                             input int rd, input int wr, input int ror, input int cbr);
        hold(1, 1, 1, 1, 4);
        check(req, "flags", int'(viol_flags), flags);
        check(req, "code",  int'(viol_code),  code);
        check(req, "reads", int'(cnt_read),   rd);
        check(req, "writes", int'(cnt_write), wr);
        check(req, "row-only", int'(cnt_ror), ror);
        check(req, "cbr",   int'(cnt_cbr),    cbr);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        int ec;
        // R12 reset state
        begin_trial();
        end_trial("R12 reset", 0, 0, 0, 0, 0, 0);

        // R6 R13 row low width sweep, min 4
        for (int w = 1; w <= 8; w++) begin
            begin_trial();
            hold(0, 1, 1, 1, w);
            ec = (w < 4) ? 2 : 0;
            end_trial("R6 R2 row low min", mask_of(ec), ec, 0, 0, 1, 0);
        end

        // R6 row low max 20
        for (int w = 19; w <= 22; w++) begin
            begin_trial();
            hold(0, 1, 1, 1, w);
            ec = (w > 20) ? 3 : 0;
            end_trial("R6 R13 row low max", mask_of(ec), ec, 0, 0, 1, 0);
        end

        // R5 row high time, min 3
        for (int h = 1; h <= 6; h++) begin
            begin_trial();
            hold(0, 1, 1, 1, 10);
            hold(1, 1, 1, 1, h);
            hold(0, 1, 1, 1, 10);
            ec = (h < 3) ? 1 : 0;
            end_trial("R5 row high min", mask_of(ec), ec, 0, 0, 2, 0);
        end

        // R7 fall-to-fall period, min 9
        for (int h = 3; h <= 7; h++) begin
            begin_trial();
            hold(0, 1, 1, 1, 4);
            hold(1, 1, 1, 1, h);
            hold(0, 1, 1, 1, 4);
            ec = (4 + h < 9) ? 4 : 0;
            end_trial("R7 period min", mask_of(ec), ec, 0, 0, 2, 0);
        end

        // R8 column pulse, min 2, page mode read on lower lane (R3)
        for (int c = 1; c <= 4; c++) begin
            begin_trial();
            hold(0, 1, 1, 1, 1);
            hold(0, 1, 0, 1, c);
            hold(0, 1, 1, 1, 2);
            hold(0, 1, 0, 1, 3);
            hold(0, 1, 1, 1, 3);
            ec = (c < 2) ? 5 : 0;
            end_trial("R8 R3 column pulse", mask_of(ec), ec, 1, 0, 0, 0);
        end

        // R8 column-to-row gap, min 2
        for (int g = 1; g <= 3; g++) begin
            begin_trial();
            hold(1, 1, 0, 1, 3);
            hold(1, 1, 1, 1, g);
            hold(0, 1, 1, 1, 8);
            ec = (g < 2) ? 6 : 0;
            end_trial("R8 R2 column-to-row gap", mask_of(ec), ec, 0, 0, 1, 0);
        end

        // R9 row hold after column fall, min 2, write cycle (R3)
        for (int r = 1; r <= 4; r++) begin
            begin_trial();
            hold(0, 1, 1, 1, 4);
            hold(0, 1, 0, 0, r);
            hold(1, 1, 0, 0, 3);
            ec = (r < 2) ? 7 : 0;
            end_trial("R9 R3 row hold write", mask_of(ec), ec, 0, 1, 0, 0);
        end

        // R10 column hold from row fall, min 5, upper lane read
        for (int c = 2; c <= 6; c++) begin
            begin_trial();
            hold(0, 1, 1, 1, 1);
            hold(0, 0, 1, 1, c);
            hold(0, 1, 1, 1, 5);
            ec = (1 + c < 5) ? 8 : 0;
            end_trial("R10 R3 column hold", mask_of(ec), ec, 1, 0, 0, 0);
        end

        // R11 write pulse, min 2
        for (int w = 1; w <= 4; w++) begin
            begin_trial();
            hold(1, 1, 1, 0, w);
            ec = (w < 2) ? 9 : 0;
            end_trial("R11 write pulse", mask_of(ec), ec, 0, 0, 0, 0);
        end

        // R1 refresh with column first; gap rule ignored when column is low
        begin_trial();
        hold(1, 1, 0, 1, 3);
        hold(1, 1, 1, 1, 1);
        hold(0, 1, 0, 1, 6);
        check("R4 no count while row low", "cbr", int'(cnt_cbr), 0);
        hold(1, 1, 0, 1, 2);
        end_trial("R1 R8 column-first refresh", 0, 0, 0, 0, 0, 1);

        // R1 hidden refresh after a read
        begin_trial();
        hold(0, 1, 1, 1, 2);
        hold(0, 1, 0, 1, 4);
        check("R4 no count mid-access", "reads", int'(cnt_read), 0);
        hold(1, 1, 0, 1, 4);
        hold(0, 1, 0, 1, 6);
        hold(1, 1, 0, 1, 2);
        end_trial("R1 R4 hidden refresh", 0, 0, 1, 0, 0, 1);

        // R1 both strobes fall on the same sample
        begin_trial();
        hold(0, 0, 0, 1, 6);
        hold(1, 0, 0, 1, 2);
        end_trial("R1 same-sample fall", 0, 0, 0, 0, 0, 1);

        // R12 first code kept: write pulse (9) then short row low (2)
        begin_trial();
        hold(1, 1, 1, 0, 1);
        hold(1, 1, 1, 1, 3);
        hold(0, 1, 1, 1, 2);
        end_trial("R12 first code kept", mask_of(9) | mask_of(2), 9, 0, 0, 1, 0);

        // R12 same-sample codes 1 and 4: lowest wins
        begin_trial();
        hold(0, 1, 1, 1, 4);
        hold(1, 1, 1, 1, 1);
        hold(0, 1, 1, 1, 5);
        end_trial("R12 lowest code wins", mask_of(1) | mask_of(4), 1, 0, 0, 2, 0);

        // R4 counts accumulate: two writes, one read, one row-only
        begin_trial();
        for (int k = 0; k < 2; k++) begin
            hold(0, 1, 1, 1, 4);
            hold(0, 1, 0, 0, 4);
            hold(1, 1, 1, 1, 6);
        end
        hold(0, 1, 1, 1, 4);
        hold(0, 0, 1, 1, 4);
        hold(1, 1, 1, 1, 6);
        hold(0, 1, 1, 1, 6);
        end_trial("R4 R3 accumulate", 0, 0, 1, 2, 1, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule